// File: doc/BRIEF.md
# PC Card Attribute-Space Configuration Registers

This block serves the attribute-memory space of a 16-bit PC Card disk device. A host access below the configuration base address reads a fixed card-information ROM. The bytes are produced by a formula, so the table stays parameterized. Four even-addressed configuration registers sit at the base. They select the card's addressing mode, start a soft reset of the ATA core, hold the card status bits and present the ready-change flag.

The block also combines three inputs into the single card interrupt line. Two are the interrupt-disable and soft-reset bits of the device-control register. The third is the interrupt request from the ATA core, which is mirrored into the status register. Reads are strobed and return data one clock later. Writes take effect at the strobing edge.

Top module: `pcCardCfgRegs`

## Requirements
- R1: After reset the addressing mode is 0. The option and status registers read 0x00, the pin register reads 0x0C, no core reset pulse is driven, and the card interrupt follows R10.
- R2: A read at a byte address below CFG_BASE (0x200) returns (a*29 + 0x5A) mod 256 when a < ROM_LEN (64), and 0x00 when ROM_LEN <= a < CFG_BASE. Writes below CFG_BASE have no effect.
- R3: A write to the option register (CFG_BASE+0) stores the data ANDed with 0xCF. The addressing-mode output is bits [5:0] of the stored value, and the register reads back the stored value.
- R4: An option write with bit 7 set does three things: it keeps bit 7 in the option register, it clears the status and pin registers, and it drives coreReset high for exactly the clock following the write.
- R5: While devCtrlIntDis is high, a status read returns the stored status with bit 1 (0x02) forced to 0.
- R6: A status write (CFG_BASE+2) leaves status = (old AND 0x82) OR (data AND 0x74). Status bit 1 holds, each clock, the value coreIrq had at the previous clock edge; it is 0 after an option soft-reset write.
- R7: A status write whose data bit 2 differs from stored status bit 2 (power-down) sets the ready-change flag, pin register bit 5 (0x20). A status write that leaves bit 2 unchanged does not set the flag. Only reset or an option soft reset clears it.
- R8: A read of the pin register (CFG_BASE+4) returns (ready-change flag AND 0x20) OR 0x0C. A write to it leaves every readable bit unchanged.
- R9: The copy register (CFG_BASE+6), odd offsets and offsets of 8 or more inside the configuration area read 0x00. Writes to them change no register.
- R10: cardIrq is high only when status bit 1 is 0, devCtrlIntDis is 0, devCtrlSoftRst is 0 and option bit 7 is 0. It follows changes of these bits and inputs without a clock edge.
- R11: attrRdData updates only at an edge where attrRd is high, and then shows the value addressed at that edge. It holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| attrRd | input | 1 | Attribute read strobe |
| attrWr | input | 1 | Attribute write strobe |
| attrAddr | input | ADDR_W | Attribute byte address |
| attrWrData | input | 8 | Write data byte |
| devCtrlIntDis | input | 1 | Device-control interrupt-disable bit |
| devCtrlSoftRst | input | 1 | Device-control soft-reset bit |
| coreIrq | input | 1 | Interrupt request level from the ATA core |
| attrRdData | output | 8 | Read data, valid the clock after attrRd |
| addrMode | output | 6 | Selected addressing mode (option bits 5:0) |
| coreReset | output | 1 | One-clock reset pulse to the ATA core |
| cardIrq | output | 1 | Card interrupt line |

## Verification
The assertions assume that every input is at a known level at each rising edge. They also assume that a write is a single clock of attrWr with a stable address and data, so an address match at one edge stands for one register access. The stimulus changes inputs only two nanoseconds after an edge, and it never leaves a strobe or data line undriven. The random phase draws its addresses from the configuration window and the ROM so that each decoded register sees many accesses. Read and write strobes may coincide in that phase, which the design allows.

// File: rtl/pccfgPkg.sv
package pccfgPkg;

  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_ROM  = 3'd1,
    SEL_OPT  = 3'd2,
    SEL_STAT = 3'd3,
    SEL_PIN  = 3'd4
  } rdSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   wrOpt;
    logic   wrStat;
    logic   wrPin;
  } cfgStrb_t;

  localparam logic [7:0] OPT_KEEP_MASK  = 8'hCF;
  localparam logic [7:0] STAT_HOLD_MASK = 8'h82;
  localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
  localparam logic [7:0] PIN_FIXED_BITS = 8'h0C;
  localparam int OPT_SRST_BIT   = 7;
  localparam int STAT_INT_BIT   = 1;
  localparam int STAT_PWRDN_BIT = 2;
  localparam int PIN_RDYCHG_BIT = 5;

  localparam int OFS_OPT  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PIN  = 4;

  // card-information ROM contents, computed rather than tabulated
  function automatic logic [7:0] romByte(input int unsigned idx);
    logic [31:0] t;
    t = idx * 32'd29 + 32'd90;
    return t[7:0];
  endfunction

endpackage

// File: rtl/pccfgCtl.sv
module pccfgCtl
  import pccfgPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h200,
  parameter int ROM_LEN  = 64
) (
  input  logic              attrRd,
  input  logic              attrWr,
  input  logic [ADDR_W-1:0] attrAddr,
  output cfgStrb_t          strb
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);

  logic              belowBase;
  logic              romHit;
  logic [ADDR_W-1:0] ofs;

  assign belowBase = attrAddr < BASE_A;
  assign ofs       = attrAddr - BASE_A;

  generate
    if (ROM_LEN >= CFG_BASE) begin : gFullRom
      assign romHit = 1'b1;
    end else begin : gPartRom
      assign romHit = attrAddr < ADDR_W'(ROM_LEN);
    end
  endgenerate

  always_comb begin
    strb        = '0;
    strb.rdEn   = attrRd;
    strb.rdSel  = SEL_ZERO;
    if (belowBase) begin
      strb.rdSel = romHit ? SEL_ROM : SEL_ZERO;
    end else begin
      unique case (ofs)
        ADDR_W'(OFS_OPT): begin
          strb.rdSel = SEL_OPT;
          strb.wrOpt = attrWr;
        end
        ADDR_W'(OFS_STAT): begin
          strb.rdSel  = SEL_STAT;
          strb.wrStat = attrWr;
        end
        ADDR_W'(OFS_PIN): begin
          strb.rdSel = SEL_PIN;
          strb.wrPin = attrWr;
        end
        default: strb.rdSel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/pccfgDp.sv
module pccfgDp
  import pccfgPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrb_t          strb,
  input  logic [ADDR_W-1:0] romIdx,
  input  logic [7:0]        wrData,
  input  logic              devCtrlIntDis,
  input  logic              devCtrlSoftRst,
  input  logic              coreIrq,
  output logic [7:0]        rdData,
  output logic [5:0]        addrMode,
  output logic              coreReset,
  output logic              cardIrq
);

  logic [7:0] optReg,  optNext;
  logic [7:0] statReg, statNext;
  logic       rdyChg,  rdyChgNext;
  logic       rstNext;
  logic [7:0] rdNext;
  logic       softRstWr;

  assign softRstWr = strb.wrOpt & wrData[OPT_SRST_BIT];

  always_comb begin
    optNext    = optReg;
    statNext   = statReg;
    rdyChgNext = rdyChg;
    rstNext    = 1'b0;
    if (strb.wrOpt) begin
      optNext = wrData & OPT_KEEP_MASK;
      if (softRstWr) begin
        statNext   = '0;
        rdyChgNext = 1'b0;
        rstNext    = 1'b1;
      end
    end else if (strb.wrStat) begin
      if (statReg[STAT_PWRDN_BIT] != wrData[STAT_PWRDN_BIT])
        rdyChgNext = 1'b1;
      statNext = (statReg & STAT_HOLD_MASK) | (wrData & STAT_LOAD_MASK);
    end else if (strb.wrPin) begin
      rdyChgNext = rdyChg;
    end
    statNext[STAT_INT_BIT] = softRstWr ? 1'b0 : coreIrq;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_ROM:  rdNext = romByte(32'(romIdx));
      SEL_OPT:  rdNext = optReg;
      SEL_STAT: begin
        rdNext = statReg;
        if (devCtrlIntDis) rdNext[STAT_INT_BIT] = 1'b0;
      end
      SEL_PIN:  rdNext = PIN_FIXED_BITS | {2'b00, rdyChg, 5'b00000};
      default:  rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optReg    <= '0;
      statReg   <= '0;
      rdyChg    <= 1'b0;
      coreReset <= 1'b0;
      rdData    <= '0;
    end else begin
      optReg    <= optNext;
      statReg   <= statNext;
      rdyChg    <= rdyChgNext;
      coreReset <= rstNext;
      if (strb.rdEn) rdData <= rdNext;
    end
  end

  assign addrMode = optReg[5:0];
  assign cardIrq  = ~statReg[STAT_INT_BIT] & ~devCtrlIntDis
                  & ~devCtrlSoftRst & ~optReg[OPT_SRST_BIT];

endmodule

// File: rtl/pcCardCfgRegs.sv
module pcCardCfgRegs
  import pccfgPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h200,
  parameter int ROM_LEN  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              attrRd,
  input  logic              attrWr,
  input  logic [ADDR_W-1:0] attrAddr,
  input  logic [7:0]        attrWrData,
  input  logic              devCtrlIntDis,
  input  logic              devCtrlSoftRst,
  input  logic              coreIrq,
  output logic [7:0]        attrRdData,
  output logic [5:0]        addrMode,
  output logic              coreReset,
  output logic              cardIrq
);

  cfgStrb_t strb;

  pccfgCtl #(
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .ROM_LEN (ROM_LEN)
  ) uCtl (
    .attrRd  (attrRd),
    .attrWr  (attrWr),
    .attrAddr(attrAddr),
    .strb    (strb)
  );

  pccfgDp #(
    .ADDR_W(ADDR_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .romIdx        (attrAddr),
    .wrData        (attrWrData),
    .devCtrlIntDis (devCtrlIntDis),
    .devCtrlSoftRst(devCtrlSoftRst),
    .coreIrq       (coreIrq),
    .rdData        (attrRdData),
    .addrMode      (addrMode),
    .coreReset     (coreReset),
    .cardIrq       (cardIrq)
  );

endmodule

// File: rtl/pcCardCfgRegsChk.sv
module pcCardCfgRegsChk #(
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h200
) (
  input logic              clk,
  input logic              rstN,
  input logic              attrRd,
  input logic              attrWr,
  input logic [ADDR_W-1:0] attrAddr,
  input logic [7:0]        attrWrData,
  input logic              devCtrlIntDis,
  input logic              devCtrlSoftRst,
  input logic [7:0]        attrRdData,
  input logic [5:0]        addrMode,
  input logic              coreReset,
  input logic              cardIrq
);

  localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] COPY_A = ADDR_W'(CFG_BASE + 6);

  // R4: a core reset pulse only follows an option write carrying bit 7
  a_r4_reset_cause: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |-> $past(attrWr && attrAddr == OPT_A && attrWrData[7]));

  // R4: such a write always produces the pulse
  a_r4_reset_follows: assert property (@(posedge clk) disable iff (!rstN)
    (attrWr && attrAddr == OPT_A && attrWrData[7]) |=> coreReset);

  // R3: the mode output takes the masked low bits of an option write
  a_r3_mode_write: assert property (@(posedge clk) disable iff (!rstN)
    (attrWr && attrAddr == OPT_A) |=> addrMode == 6'($past(attrWrData) & 8'h0F));

  // R3: without an option write the mode holds
  a_r3_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(attrWr && attrAddr == OPT_A) |=> $stable(addrMode));

  // R10: either device-control bit silences the card interrupt
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    (devCtrlIntDis || devCtrlSoftRst) |-> !cardIrq);

  // R11: read data holds between read strobes
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !attrRd |=> $stable(attrRdData));

  // R9: a read of the copy register returns zero
  a_r9_copy_zero: assert property (@(posedge clk) disable iff (!rstN)
    (attrRd && attrAddr == COPY_A) |=> attrRdData == 8'h00);

endmodule

bind pcCardCfgRegs pcCardCfgRegsChk #(
  .ADDR_W  (ADDR_W),
  .CFG_BASE(CFG_BASE)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .attrRd        (attrRd),
  .attrWr        (attrWr),
  .attrAddr      (attrAddr),
  .attrWrData    (attrWrData),
  .devCtrlIntDis (devCtrlIntDis),
  .devCtrlSoftRst(devCtrlSoftRst),
  .attrRdData    (attrRdData),
  .addrMode      (addrMode),
  .coreReset     (coreReset),
  .cardIrq       (cardIrq)
);

// File: tb/tb_pcCardCfgRegs.sv
`timescale 1ns/1ps
module tb_pcCardCfgRegs;

  localparam int ADDR_W = 12;
  localparam int BASE   = 'h200;
  localparam int ROMLEN = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              attrRd = 1'b0;
  logic              attrWr = 1'b0;
  logic [ADDR_W-1:0] attrAddr = '0;
  logic [7:0]        attrWrData = '0;
  logic              devCtrlIntDis = 1'b0;
  logic              devCtrlSoftRst = 1'b0;
  logic              coreIrq = 1'b0;
  logic [7:0]        attrRdData;
  logic [5:0]        addrMode;
  logic              coreReset;
  logic              cardIrq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pcCardCfgRegs #(.ADDR_W(ADDR_W), .CFG_BASE(BASE), .ROM_LEN(ROMLEN)) dut (
    .clk(clk), .rstN(rstN), .attrRd(attrRd), .attrWr(attrWr),
    .attrAddr(attrAddr), .attrWrData(attrWrData),
    .devCtrlIntDis(devCtrlIntDis), .devCtrlSoftRst(devCtrlSoftRst),
    .coreIrq(coreIrq), .attrRdData(attrRdData), .addrMode(addrMode),
    .coreReset(coreReset), .cardIrq(cardIrq));

  // behavioural reference model, updated at each rising edge
  int mOpt = 0, mStat = 0, mRdy = 0, mRd = 0, mRst = 0;

  function automatic int expRead(int a);
    if (a < BASE) return (a < ROMLEN) ? ((a * 29 + 90) % 256) : 0;
    case (a - BASE)
      0: return mOpt;
      2: return devCtrlIntDis ? (mStat & 'hFD) : mStat;
      4: return (mRdy ? 'h20 : 0) | 'h0C;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOpt = 0; mStat = 0; mRdy = 0; mRd = 0; mRst = 0;
    end else begin
      int d, a;
      bit srst;
      d = int'(attrWrData);
      a = int'(attrAddr);
      srst = 0;
      mRst = 0;
      if (attrRd) mRd = expRead(a);
      if (attrWr && a == BASE) begin
        mOpt = d & 'hCF;
        if (d & 'h80) begin
          mStat = 0; mRdy = 0; mRst = 1; srst = 1;
        end
      end else if (attrWr && a == BASE + 2) begin
        if (((mStat ^ d) & 'h04) != 0) mRdy = 1;
        mStat = (mStat & 'h82) | (d & 'h74);
      end
      mStat = (mStat & 'hFD) | ((coreIrq && !srst) ? 'h02 : 0);
    end
  end

  function automatic bit expIrq();
    return ((mStat & 'h02) == 0) && !devCtrlIntDis && !devCtrlSoftRst
           && ((mOpt & 'h80) == 0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R11 rdData", int'(attrRdData), mRd);
      check("R3 addrMode", int'(addrMode), mOpt & 'h3F);
      check("R4 coreReset", int'(coreReset), mRst);
      check("R10 cardIrq", int'(cardIrq), int'(expIrq()));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int d);
    attrWr = 1'b1; attrAddr = ADDR_W'(a); attrWrData = 8'(d);
    cyc();
    attrWr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    attrRd = 1'b1; attrAddr = ADDR_W'(a);
    cyc();
    attrRd = 1'b0;
    #1 d = int'(attrRdData);
  endtask

  initial begin
    int v;
    int lfsr;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    check("R1 mode", int'(addrMode), 0);
    check("R1 irq", int'(cardIrq), 1);
    check("R1 reset pulse", int'(coreReset), 0);
    rd(BASE, v);      check("R1 option", v, 'h00);
    rd(BASE + 2, v);  check("R1 status", v, 'h00);
    rd(BASE + 4, v);  check("R1 pin", v, 'h0C);

    // R2 ROM and gap
    rd(0, v);         check("R2 rom0", v, 'h5A);
    rd(1, v);         check("R2 rom1", v, 'h77);
    rd(63, v);        check("R2 rom63", v, (63 * 29 + 90) % 256);
    rd(64, v);        check("R2 past rom", v, 0);
    rd(BASE - 1, v);  check("R2 below base", v, 0);
    wr(1, 'hFF);
    rd(1, v);         check("R2 rom write ignored", v, 'h77);

    // R3 option masking
    wr(BASE, 'h3F);
    check("R3 mode 3F", int'(addrMode), 'h0F);
    rd(BASE, v);      check("R3 option 3F", v, 'h0F);
    wr(BASE, 'h41);
    rd(BASE, v);      check("R3 option 41", v, 'h41);
    check("R3 mode 41", int'(addrMode), 'h01);

    // R6 / R7 status writes and ready change
    wr(BASE + 2, 'h10);
    rd(BASE + 2, v);  check("R6 status 10", v, 'h10);
    rd(BASE + 4, v);  check("R7 no toggle", v, 'h0C);
    wr(BASE + 2, 'h04);
    rd(BASE + 4, v);  check("R7 toggle sets flag", v, 'h2C);
    wr(BASE + 2, 'hFF);
    rd(BASE + 2, v);  check("R6 status FF", v, 'h74);

    // R6 / R10 / R5 interrupt bit
    coreIrq = 1'b1;
    cyc();
    check("R10 irq low with status bit", int'(cardIrq), 0);
    rd(BASE + 2, v);  check("R6 int bit mirrors", v, 'h76);
    devCtrlIntDis = 1'b1;
    rd(BASE + 2, v);  check("R5 masked read", v, 'h74);
    devCtrlIntDis = 1'b0;
    coreIrq = 1'b0;
    cyc();
    check("R10 irq back", int'(cardIrq), 1);

    // R8 pin writes
    wr(BASE + 4, 'hFF);
    rd(BASE + 4, v);  check("R8 pin write kept", v, 'h2C);
    wr(BASE + 4, 'h00);
    rd(BASE + 4, v);  check("R8 pin write zero", v, 'h2C);

    // R9 unmapped configuration offsets
    wr(BASE + 6, 'hFF);
    wr(BASE + 1, 'hFF);
    wr(BASE + 8, 'hFF);
    rd(BASE + 6, v);  check("R9 copy reads zero", v, 0);
    rd(BASE + 9, v);  check("R9 odd reads zero", v, 0);
    rd(BASE, v);      check("R9 option untouched", v, 'h41);
    rd(BASE + 2, v);  check("R9 status untouched", v, 'h74);

    // R10 device-control soft reset gate
    devCtrlSoftRst = 1'b1;
    #1 check("R10 dev srst gate", int'(cardIrq), 0);
    devCtrlSoftRst = 1'b0;
    #1 check("R10 dev srst release", int'(cardIrq), 1);

    // R4 option soft reset
    attrWr = 1'b1; attrAddr = ADDR_W'(BASE); attrWrData = 8'h83;
    cyc();
    attrWr = 1'b0;
    check("R4 pulse high", int'(coreReset), 1);
    check("R10 option srst gate", int'(cardIrq), 0);
    cyc();
    check("R4 pulse ends", int'(coreReset), 0);
    rd(BASE, v);      check("R4 option kept", v, 'h83);
    rd(BASE + 2, v);  check("R4 status cleared", v, 0);
    rd(BASE + 4, v);  check("R4 pin cleared", v, 'h0C);
    wr(BASE, 'h00);
    check("R10 option srst release", int'(cardIrq), 1);

    // R11 read data holds
    rd(BASE + 4, v);
    repeat (4) cyc();
    check("R11 hold", int'(attrRdData), 'h0C);

    // mixed traffic, compared against the model every clock
    lfsr = 'h1ACE;
    for (int i = 0; i < 600; i++) begin
      int r, a;
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      r = lfsr;
      a = ((r & 3) == 0) ? (r >> 4) % 80 : BASE + ((r >> 2) % 10);
      attrRd = r[6];
      attrWr = r[7] && ((r >> 8) % 4 != 0 || a != BASE);
      attrAddr = ADDR_W'(a);
      attrWrData = 8'(r >> 5);
      coreIrq = r[11];
      devCtrlIntDis = r[12] & r[13];
      devCtrlSoftRst = r[14] & r[15] & r[9];
      cyc();
    end
    attrRd = 1'b0; attrWr = 1'b0;
    cyc();
    cyc();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule